// File: doc/BRIEF.md
# QDR SRAM Command and Write-Path Controller

This block turns a request port in the 1x clock domain into the pin-level command, address and write-data traffic of a quad-data-rate SRAM that has separate read and write ports. Each 1x cycle the system presents a two-bit command, a read address, a write address and a 36-bit write data word. The block registers the request and drives it to the memory over one K clock period.

The read half goes out first and the write half follows on the same pins. One shared address bus carries the read address before K rises and the write address before K_bar rises. The write data leaves as two 18-bit words, one per half period.

The differential K/K_bar pair comes from a toggle flop on the rising edge of the 2x clock. All address, select and data outputs are launched on the falling edge of the 2x clock, so every output sits in the middle of the half period that samples it. A low `pll_lock` or a low `rst_n` puts the pins into a defined idle state at once.

Top module: `qdr_cmd_ctrl`

## Requirements
- R1: `k_clk` and `k_clk_n` are always complementary. While running, both toggle on every rising edge of `clk_2x`, and `k_clk` rises one `clk_2x` period after each rising edge of `clk_1x`.
- R2: A request sampled at a rising edge E of `clk_1x` drives its read-phase pin values from the `clk_2x` falling edge half a 2x period after E. It drives its write-phase values from the next `clk_2x` falling edge. Each set is held until the following falling edge.
- R3: Command encoding: 2'b00 is idle, 2'b01 is read, 2'b10 is write and 2'b11 is read and write in the same cycle. Bit 0 requests a read and bit 1 requests a write.
- R4: `rps_n` is low during the read phase exactly when the request includes a read. It is high in every write phase and for idle requests.
- R5: `wps_n` is low during the read phase exactly when the request includes a write. It is high in every write phase and for non-write requests.
- R6: `sram_addr` carries the read address in the read phase of a read, and the write address in the write phase of a write. It is zero in any phase whose port is unused.
- R7: For a write, `sram_din` carries `wr_data[17:0]` in the read phase (first word) and `wr_data[35:18]` in the write phase (second word). It is zero when no write is requested.
- R8: For a write, both bits of `bws_n` are low in both phases. Bit 0 covers data bits 8:0 and bit 1 covers bits 17:9. Otherwise `bws_n` is 2'b11.
- R9: While `rst_n` or `pll_lock` is low, the outputs take these values without waiting for a clock edge:
  - `rps_n`, `wps_n` and `bws_n` are all high;
  - `sram_addr` and `sram_din` are zero;
  - `k_clk` is low and `k_clk_n` is high.
- R10: After `rst_n` and `pll_lock` are both high, the second rising edge of `clk_1x` starts the K clock: `k_clk` first rises one 2x period later. The third rising edge of `clk_1x` is the first at which a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_1x | input | 1 | System-side clock, rising edges aligned to every other `clk_2x` rising edge |
| clk_2x | input | 1 | Double-rate clock for pin launch and K generation |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | Clock-source lock indication; low forces the idle state |
| cmd | input | 2 | Request command (R3 encoding) |
| rd_addr | input | 18 | Read address of the request |
| wr_addr | input | 18 | Write address of the request |
| wr_data | input | 36 | Write data; low half is the first word |
| k_clk | output | 1 | Memory clock K |
| k_clk_n | output | 1 | Memory clock K_bar |
| rps_n | output | 1 | Active-low read port select |
| wps_n | output | 1 | Active-low write port select |
| bws_n | output | 2 | Active-low byte write selects |
| sram_addr | output | 18 | Shared address bus |
| sram_din | output | 18 | Double-rate write data to the memory |

## Verification
The state that matters is the K phase and the registered request. A K toggle flop that slips by one 2x edge shows at the first falling edge after the slip: every read-phase value then appears while K is already high, so the selects, the address and the data words swap halves. A stale or mis-decoded request shows within one 1x cycle as a wrong select level or a wrong address on the shared bus. The bench therefore compares every pin at every 2x falling edge. This includes the reset and lock-loss windows and the start-up edges where the K clock must stay parked.

// File: rtl/qdr_ctrl_pkg.sv
package qdr_ctrl_pkg;

  // Request command; bit 0 asks for a read, bit 1 for a write.
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_BOTH  = 2'b11
  } qdr_cmd_e;

  function automatic logic cmd_has_rd(qdr_cmd_e c);
    return (c == CMD_READ) || (c == CMD_BOTH);
  endfunction

  function automatic logic cmd_has_wr(qdr_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_BOTH);
  endfunction

endpackage

// File: rtl/qdr_rst_sync.sv
// Asserts both domain resets at once; releases them in a fixed order:
// first the 1x domain, then the 2x domain on the next 2x falling edge.
module qdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_1x,
  input  logic clk_2x,
  input  logic arst_n,
  output logic rst_1x_n,
  output logic rst_2x_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              fall_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_1x or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  always_ff @(negedge clk_2x or negedge arst_n) begin
    if (!arst_n) fall_q <= 1'b0;
    else         fall_q <= sync_q[STAGES-1];
  end

  assign rst_1x_n = sync_q[STAGES-1];
  assign rst_2x_n = fall_q;

endmodule

// File: rtl/qdr_req_stage.sv
// 1x-domain request register.
module qdr_req_stage
  import qdr_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              q_rd,
  output logic              q_wr,
  output logic [ADDR_W-1:0] q_raddr,
  output logic [ADDR_W-1:0] q_waddr,
  output logic [DATA_W-1:0] q_wdata
);

  logic              rd_d, wr_d;
  logic [ADDR_W-1:0] raddr_d, waddr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              cap_en;

  always_comb begin
    rd_d    = cmd_has_rd(qdr_cmd_e'(cmd));
    wr_d    = cmd_has_wr(qdr_cmd_e'(cmd));
    cap_en  = 1'b1;
    raddr_d = rd_d ? rd_addr : '0;
    waddr_d = wr_d ? wr_addr : '0;
    wdata_d = wr_d ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rd    <= 1'b0;
      q_wr    <= 1'b0;
      q_raddr <= '0;
      q_waddr <= '0;
      q_wdata <= '0;
    end else if (cap_en) begin
      q_rd    <= rd_d;
      q_wr    <= wr_d;
      q_raddr <= raddr_d;
      q_waddr <= waddr_d;
      q_wdata <= wdata_d;
    end
  end

endmodule

// File: rtl/qdr_kclk_gen.sv
// Toggle flop on the 2x rising edge; K and K_bar are registered copies.
// The toggle resets to 1 so that K rises mid 1x cycle after release.
module qdr_kclk_gen (
  input  logic clk_2x,
  input  logic rst_n,
  output logic k_clk,
  output logic k_clk_n
);

  logic tgl_q, tgl_d;

  always_comb tgl_d = ~tgl_q;

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q   <= 1'b1;
      k_clk   <= 1'b0;
      k_clk_n <= 1'b1;
    end else begin
      tgl_q   <= tgl_d;
      k_clk   <= tgl_q;
      k_clk_n <= ~tgl_q;
    end
  end

endmodule

// File: rtl/qdr_launch.sv
// Falling-edge launch of pins. K low now means K rises next: read phase.
module qdr_launch #(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                 clk_2x,
  input  logic                 rst_n,
  input  logic                 k_now,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    raddr,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [2*WORD_W-1:0]  wdata,
  output logic                 rps_n,
  output logic                 wps_n,
  output logic [WORD_W/BYTE_W-1:0] bws_n,
  output logic [ADDR_W-1:0]    addr,
  output logic [WORD_W-1:0]    dout
);

  localparam int NBYTE = WORD_W / BYTE_W;

  logic                rd_ph;
  logic                rps_d, wps_d;
  logic [NBYTE-1:0]    bws_d;
  logic [ADDR_W-1:0]   addr_d;
  logic [WORD_W-1:0]   word_sel, dout_d;
  logic [WORD_W-1:0]   words [2];

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_word
      assign words[gi] = wdata[gi*WORD_W +: WORD_W];
    end
    for (gi = 0; gi < NBYTE; gi++) begin : g_bws
      assign bws_d[gi] = ~wr;
    end
  endgenerate

  always_comb begin
    rd_ph    = ~k_now;
    rps_d    = ~(rd_ph & rd);
    wps_d    = ~(rd_ph & wr);
    addr_d   = rd_ph ? (rd ? raddr : '0) : (wr ? waddr : '0);
    word_sel = rd_ph ? words[0] : words[1];
    dout_d   = wr ? word_sel : '0;
  end

  always_ff @(negedge clk_2x or negedge rst_n) begin
    if (!rst_n) begin
      rps_n <= 1'b1;
      wps_n <= 1'b1;
      bws_n <= '1;
      addr  <= '0;
      dout  <= '0;
    end else begin
      rps_n <= rps_d;
      wps_n <= wps_d;
      bws_n <= bws_d;
      addr  <= addr_d;
      dout  <= dout_d;
    end
  end

endmodule

// File: rtl/qdr_cmd_ctrl.sv
module qdr_cmd_ctrl #(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                       clk_1x,
  input  logic                       clk_2x,
  input  logic                       rst_n,
  input  logic                       pll_lock,
  input  logic [1:0]                 cmd,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [2*WORD_W-1:0]        wr_data,
  output logic                       k_clk,
  output logic                       k_clk_n,
  output logic                       rps_n,
  output logic                       wps_n,
  output logic [WORD_W/BYTE_W-1:0]   bws_n,
  output logic [ADDR_W-1:0]          sram_addr,
  output logic [WORD_W-1:0]          sram_din
);

  localparam int DATA_W = 2 * WORD_W;
  localparam int NBYTE  = WORD_W / BYTE_W;

  logic              arst_n, rst_1x_n, rst_2x_n;
  logic              q_rd, q_wr;
  logic [ADDR_W-1:0] q_raddr, q_waddr;
  logic [DATA_W-1:0] q_wdata;

  assign arst_n = rst_n & pll_lock;

  qdr_rst_sync #(.STAGES(2)) i_rst (
    .clk_1x(clk_1x), .clk_2x(clk_2x), .arst_n(arst_n),
    .rst_1x_n(rst_1x_n), .rst_2x_n(rst_2x_n)
  );

  qdr_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_req (
    .clk(clk_1x), .rst_n(rst_1x_n), .cmd(cmd),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_rd(q_rd), .q_wr(q_wr), .q_raddr(q_raddr),
    .q_waddr(q_waddr), .q_wdata(q_wdata)
  );

  qdr_kclk_gen i_kgen (
    .clk_2x(clk_2x), .rst_n(rst_2x_n), .k_clk(k_clk), .k_clk_n(k_clk_n)
  );

  qdr_launch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_launch (
    .clk_2x(clk_2x), .rst_n(rst_2x_n), .k_now(k_clk),
    .rd(q_rd), .wr(q_wr), .raddr(q_raddr), .waddr(q_waddr), .wdata(q_wdata),
    .rps_n(rps_n), .wps_n(wps_n), .bws_n(bws_n),
    .addr(sram_addr), .dout(sram_din)
  );

endmodule

// File: rtl/qdr_cmd_ctrl_chk.sv
module qdr_cmd_ctrl_chk #(
  parameter int NBYTE = 2
) (
  input logic             clk_2x,
  input logic             rst_n,
  input logic             pll_lock,
  input logic             rst_2x_n,
  input logic             k_clk,
  input logic             k_clk_n,
  input logic             rps_n,
  input logic             wps_n,
  input logic [NBYTE-1:0] bws_n
);

  // R1: the clock pair never shows the same level
  a_r1_k_pair: assert property (@(posedge clk_2x) disable iff (!rst_n)
    k_clk != k_clk_n);

  // R1: K changes between consecutive 2x falling edges while running
  a_r1_k_toggle: assert property (@(negedge clk_2x) disable iff (!rst_2x_n)
    $past(rst_2x_n) |-> (k_clk != $past(k_clk)));

  // R4/R5: a port select seen low means K has just risen to sample it
  a_r4_sel_in_k_phase: assert property (@(negedge clk_2x) disable iff (!rst_2x_n)
    (!rps_n || !wps_n) |-> k_clk);

  // R8: a write select is followed by byte selects low in the write phase
  a_r8_bws_follow: assert property (@(negedge clk_2x) disable iff (!rst_2x_n)
    !wps_n |=> (bws_n == '0));

  // R9: lost lock parks the pins
  a_r9_lock_idle: assert property (@(posedge clk_2x) disable iff (!rst_n)
    !pll_lock |-> (rps_n && wps_n && (&bws_n) && !k_clk && k_clk_n));

endmodule

bind qdr_cmd_ctrl qdr_cmd_ctrl_chk #(.NBYTE(NBYTE)) i_chk (
  .clk_2x(clk_2x), .rst_n(rst_n), .pll_lock(pll_lock), .rst_2x_n(rst_2x_n),
  .k_clk(k_clk), .k_clk_n(k_clk_n), .rps_n(rps_n), .wps_n(wps_n),
  .bws_n(bws_n)
);

// File: tb/test_qdr_cmd_ctrl.sv
module test_qdr_cmd_ctrl;

  localparam int CLK_T = 10;  // clk_2x period
  localparam int AW = 18;
  localparam int WW = 18;

  logic          clk_1x, clk_2x, rst_n, pll_lock;
  logic [1:0]    cmd;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [2*WW-1:0] wr_data;
  logic          k_clk, k_clk_n, rps_n, wps_n;
  logic [1:0]    bws_n;
  logic [AW-1:0] sram_addr;
  logic [WW-1:0] sram_din;

  int checks = 0;
  int errors = 0;

  qdr_cmd_ctrl i_qdr_cmd_ctrl (
    .clk_1x(clk_1x), .clk_2x(clk_2x), .rst_n(rst_n), .pll_lock(pll_lock),
    .cmd(cmd), .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
    .k_clk(k_clk), .k_clk_n(k_clk_n), .rps_n(rps_n), .wps_n(wps_n),
    .bws_n(bws_n), .sram_addr(sram_addr), .sram_din(sram_din)
  );

  initial begin
    clk_2x = 1'b0;
    forever #(CLK_T/2) clk_2x = ~clk_2x;
  end

  initial begin
    clk_1x = 1'b0;
    #(CLK_T/2);
    forever begin
      clk_1x = 1'b1; #CLK_T;
      clk_1x = 1'b0; #CLK_T;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural model: start-up counter, accepted request, phase index.
  int        up_cnt = 0;
  int        ph = 0;
  int        cur_ph;
  logic [1:0]      m_cmd = 2'b00;
  logic [AW-1:0]   m_ra = '0, m_wa = '0;
  logic [2*WW-1:0] m_wd = '0;

  always @(posedge clk_1x) begin
    if (!(rst_n && pll_lock)) up_cnt = 0;
    else if (up_cnt < 3)      up_cnt = up_cnt + 1;
    if (up_cnt >= 3) begin
      m_cmd = cmd; m_ra = rd_addr; m_wa = wr_addr; m_wd = wr_data;
    end else begin
      m_cmd = 2'b00; m_ra = '0; m_wa = '0; m_wd = '0;
    end
    ph = 0;
  end

  always @(negedge clk_2x) begin
    logic e_rd, e_wr, e_k;
    cur_ph = ph;
    ph = ph + 1;
    #(CLK_T/4);
    if (!(rst_n && pll_lock)) begin
      // R9: idle pins while reset or lock is low
      chk("R9", "k", k_clk, 0);
      chk("R9", "kn", k_clk_n, 1);
      chk("R9", "rps", rps_n, 1);
      chk("R9", "wps", wps_n, 1);
      chk("R9", "bws", bws_n, 2'b11);
      chk("R9", "addr", sram_addr, 0);
      chk("R9", "din", sram_din, 0);
    end else if (up_cnt < 2) begin
      // R10: K stays parked before the second 1x edge after release
      chk("R10", "k", k_clk, 0);
      chk("R10", "kn", k_clk_n, 1);
      chk("R10", "rps", rps_n, 1);
      chk("R10", "wps", wps_n, 1);
    end else begin
      // R3 decode: bit0 read, bit1 write
      e_rd = m_cmd[0];
      e_wr = m_cmd[1];
      e_k  = (cur_ph == 1);
      chk("R1", "k", k_clk, e_k);
      chk("R1", "kn", k_clk_n, !e_k);
      if (cur_ph == 0) begin
        // R2 read phase: first falling edge after the 1x edge
        chk("R4", "rps", rps_n, !e_rd);
        chk("R5", "wps", wps_n, !e_wr);
        chk("R6", "addr_rd_phase", sram_addr, e_rd ? m_ra : '0);
        chk("R7", "din_word0", sram_din, e_wr ? m_wd[WW-1:0] : '0);
      end else begin
        // R2 write phase: second falling edge
        chk("R4", "rps_wph", rps_n, 1);
        chk("R5", "wps_wph", wps_n, 1);
        chk("R6", "addr_wr_phase", sram_addr, e_wr ? m_wa : '0);
        chk("R7", "din_word1", sram_din, e_wr ? m_wd[2*WW-1:WW] : '0);
      end
      chk("R8", "bws", bws_n, e_wr ? 2'b00 : 2'b11);
    end
  end

  task automatic drive(input logic [1:0] c, input logic [AW-1:0] ra,
                       input logic [AW-1:0] wa, input logic [2*WW-1:0] wd);
    @(negedge clk_1x);
    cmd = c; rd_addr = ra; wr_addr = wa; wr_data = wd;
  endtask

  task automatic drive_rand(input int n);
    for (int i = 0; i < n; i++)
      drive(2'($urandom), AW'($urandom), AW'($urandom), {4'($urandom), 32'($urandom)});
  endtask

  initial begin
    #(CLK_T * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pll_lock = 1'b0;
    cmd = 2'b00; rd_addr = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk_1x);
    pll_lock = 1'b1;
    repeat (2) @(negedge clk_1x);
    rst_n = 1'b1;
    // R3: every encoding, boundary addresses and data patterns
    drive(2'b00, 18'h3FFFF, 18'h3FFFF, '1);
    drive(2'b01, 18'h00001, 18'h2AAAA, 36'h1_2345_6789);
    drive(2'b10, 18'h15555, 18'h3FFFF, 36'hF_0F0F_0F0F);
    drive(2'b11, 18'h3FFFF, 18'h00000, 36'h0_0003_FFFF);
    drive(2'b11, 18'h00000, 18'h3FFFF, 36'hF_FFFC_0000);
    drive(2'b10, 18'h12345, 18'h00001, '1);
    drive(2'b01, 18'h3FFFF, 18'h12345, '0);
    drive(2'b00, 18'h1, 18'h2, 36'h5);
    drive_rand(150);
    // lock loss mid-stream (R9, R10)
    @(negedge clk_1x); pll_lock = 1'b0;
    drive_rand(4);
    @(negedge clk_1x); pll_lock = 1'b1;
    drive_rand(30);
    // reset pulse (R9, R10)
    @(negedge clk_1x); rst_n = 1'b0;
    drive_rand(3);
    @(negedge clk_1x); rst_n = 1'b1;
    drive_rand(30);
    drive(2'b00, '0, '0, '0);
    repeat (4) @(negedge clk_1x);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule